// File: doc/BRIEF.md
# Bit-Serial Column-MAC Neuron

This block is one neuron of a digital compute-in-memory array. It keeps one weight for each of 128 column slices in a register array. Weight precision is set between 1 and 16 bits. During a computation, one activation bit per column arrives on every accepted cycle, least significant bit first. Each slice multiplies its input bit by every bit of its stored weight and adds the product to a partial sum that ripples along the row of slices. Each slice is 7 bits wider than the largest weight, so the sum over all 128 slices is exact.

A post-accumulator adds each cycle's row sum, shifted left by the index of the input bit, into a 39-bit result. The input precision is simply the number of accepted bit cycles. When both precisions are 1, the neuron works as a binary neuron. In that mode each bit product is the XNOR of the input bit and weight bit 0, and the result is the count of matching columns.

A typical use: load the weights while the neuron is idle, pulse `start` together with the two precision settings, stream the input bits with `in_valid`, and read `result` when `done` pulses.

Top module: `cmac_neuron`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all zero.
- R2: While `busy` is low, `wr_en` stores `wr_data` as the weight of column `wr_idx`. During a computation, only the low N = `cfg_wprec_m1`+1 bits of each weight are used, and higher stored bits have no effect.
- R3: A write presented while `busy` is high is dropped, and the stored weight keeps its earlier value.
- R4: In multi-bit mode (either precision above 1), operands are unsigned. The row sum for one input cycle is the sum over columns of input bit AND (weight masked to N bits).
- R5: The run takes M = `cfg_iprec_m1`+1 accepted cycles. The k-th accepted cycle (k from 0) carries input bit k. `result` equals the sum over k of (row sum of cycle k) << k.
- R6: When `cfg_wprec_m1` and `cfg_iprec_m1` are both 0 (binary mode), the run takes one accepted cycle. `result` is the number of columns whose input bit equals weight bit 0.
- R7: `done` is high for exactly one cycle: the cycle right after the one in which the last input bit was accepted. In that cycle `busy` is already low.
- R8: `start` is taken only when `busy` is low. It latches both precision settings and clears `result` to zero. While idle with no start, `result` holds its value.
- R9: Cycles with `in_valid` low during a run add nothing. A `start` raised during a run is ignored.
- R10: With all weights and all input bits at their 16-bit maximum, the result is the exact value 128·(2^16−1)^2, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight write strobe |
| wr_idx | input | 7 | Column addressed by a write |
| wr_data | input | 16 | Weight value to store |
| cfg_wprec_m1 | input | 4 | Weight precision minus one, latched at start |
| cfg_iprec_m1 | input | 4 | Input precision minus one, latched at start |
| start | input | 1 | Begin a computation |
| in_valid | input | 1 | Input bit lane vector is valid this cycle |
| in_bits | input | 128 | One input bit per column |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 39 | Accumulated neuron output |

## Verification
The assertions assume two things about the environment. First, `start` is offered only when the neuron is idle or is ignored. Second, no more than the configured number of input cycles are accepted, so the bit index never passes the latched input precision. They also assume that weights are unsigned, so every accumulation step can only grow `result`, and in binary mode the row sum cannot exceed the column count.

The stimulus stays inside these assumptions. It loads weights only while `busy` is low, apart from deliberate writes during a run. It sends exactly M valid cycles, with optional idle gaps. Every spurious start and mid-run write falls inside a run, where the requirements say it must be ignored.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/cmac_weight_store.sv
module cmac_weight_store #(
  parameter int NUM_COLS = 128,
  parameter int W_MAX    = 16,
  localparam int IDX_W   = $clog2(NUM_COLS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [W_MAX-1:0]                  wr_data,
  input  logic                              lock,
  output logic [NUM_COLS-1:0][W_MAX-1:0]    weights
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic             col_we;
    logic [W_MAX-1:0] col_d;
    logic [W_MAX-1:0] col_q;

    always_comb begin
      col_we = wr_en && !lock && (wr_idx == IDX_W'(c));
      col_d  = col_we ? wr_data : col_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) col_q <= '0;
      else        col_q <= col_d;
    end

    assign weights[c] = col_q;
  end

  // A locked store must not change (write blocking)
  assert_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(weights));
endmodule

// File: rtl/cmac_slice.sv
module cmac_slice #(
  parameter int W_MAX  = 16,
  parameter int PSUM_W = 23
) (
  input  logic              in_bit,
  input  logic [W_MAX-1:0]  weight,
  input  logic [W_MAX-1:0]  wmask,
  input  logic              binary,
  input  logic [PSUM_W-1:0] psum_in,
  output logic [PSUM_W-1:0] psum_out
);
  logic [W_MAX-1:0]  bit_prod;
  logic [PSUM_W-1:0] prod_ext;

  always_comb begin
    if (binary) begin
      bit_prod = '0;
      bit_prod[0] = ~(in_bit ^ weight[0]);
    end else begin
      bit_prod = weight & wmask & {W_MAX{in_bit}};
    end
    prod_ext = PSUM_W'(bit_prod);
    psum_out = psum_in + prod_ext;
  end
endmodule

// File: rtl/cmac_ctrl.sv
module cmac_ctrl
  import cmac_pkg::*;
#(
  parameter int NUM_COLS = 128,
  parameter int W_MAX    = 16,
  parameter int I_MAX    = 16,
  parameter int PSUM_W   = 23,
  localparam int RES_W   = PSUM_W + I_MAX,
  localparam int WCFG_W  = $clog2(W_MAX),
  localparam int ICFG_W  = $clog2(I_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [WCFG_W-1:0] cfg_wprec_m1,
  input  logic [ICFG_W-1:0] cfg_iprec_m1,
  input  logic [PSUM_W-1:0] row_sum,
  output logic              busy,
  output logic              done,
  output logic [W_MAX-1:0]  wmask,
  output logic              binary,
  output logic [RES_W-1:0]  result
);
  run_state_t        state_q, state_n;
  logic [ICFG_W-1:0] idx_q, idx_n;
  logic [ICFG_W-1:0] iprec_q, iprec_n;
  logic [WCFG_W-1:0] wprec_q, wprec_n;
  logic [RES_W-1:0]  acc_q, acc_n;
  logic              done_q, done_n;
  logic [RES_W-1:0]  addend;

  assign addend = RES_W'(row_sum) << idx_q;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    iprec_n = iprec_q;
    wprec_n = wprec_q;
    acc_n   = acc_q;
    done_n  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start) begin
        state_n = ST_RUN;
        idx_n   = '0;
        acc_n   = '0;
        iprec_n = cfg_iprec_m1;
        wprec_n = cfg_wprec_m1;
      end
    end else if (in_valid) begin
      acc_n = acc_q + addend;
      if (idx_q == iprec_q) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      iprec_q <= '0;
      wprec_q <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      iprec_q <= iprec_n;
      wprec_q <= wprec_n;
      acc_q   <= acc_n;
      done_q  <= done_n;
    end
  end

  for (genvar i = 0; i < W_MAX; i++) begin : g_mask
    assign wmask[i] = (WCFG_W'(i) <= wprec_q);
  end

  assign binary = (wprec_q == '0) && (iprec_q == '0);
  assign busy   = (state_q == ST_RUN);
  assign done   = done_q;
  assign result = acc_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= iprec_q));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> (result >= $past(result)));
  assert_binary_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && binary) |-> (row_sum <= PSUM_W'(NUM_COLS)));
endmodule

// File: rtl/cmac_neuron.sv
module cmac_neuron #(
  parameter int NUM_COLS = 128,
  parameter int W_MAX    = 16,
  parameter int I_MAX    = 16,
  localparam int EXT_W   = $clog2(NUM_COLS),
  localparam int PSUM_W  = W_MAX + EXT_W,
  localparam int RES_W   = PSUM_W + I_MAX,
  localparam int IDX_W   = $clog2(NUM_COLS),
  localparam int WCFG_W  = $clog2(W_MAX),
  localparam int ICFG_W  = $clog2(I_MAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [W_MAX-1:0]    wr_data,
  input  logic [WCFG_W-1:0]   cfg_wprec_m1,
  input  logic [ICFG_W-1:0]   cfg_iprec_m1,
  input  logic                start,
  input  logic                in_valid,
  input  logic [NUM_COLS-1:0] in_bits,
  output logic                busy,
  output logic                done,
  output logic [RES_W-1:0]    result
);
  logic [NUM_COLS-1:0][W_MAX-1:0] weights;
  logic [W_MAX-1:0]               wmask;
  logic                           binary;
  logic [PSUM_W-1:0]              chain [NUM_COLS+1];

  cmac_weight_store #(.NUM_COLS(NUM_COLS), .W_MAX(W_MAX)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .lock    (busy),
    .weights (weights)
  );

  assign chain[0] = '0;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_slice
    cmac_slice #(.W_MAX(W_MAX), .PSUM_W(PSUM_W)) u_slice (
      .in_bit   (in_bits[c]),
      .weight   (weights[c]),
      .wmask    (wmask),
      .binary   (binary),
      .psum_in  (chain[c]),
      .psum_out (chain[c+1])
    );
  end

  cmac_ctrl #(
    .NUM_COLS (NUM_COLS),
    .W_MAX    (W_MAX),
    .I_MAX    (I_MAX),
    .PSUM_W   (PSUM_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .in_valid     (in_valid),
    .cfg_wprec_m1 (cfg_wprec_m1),
    .cfg_iprec_m1 (cfg_iprec_m1),
    .row_sum      (chain[NUM_COLS]),
    .busy         (busy),
    .done         (done),
    .wmask        (wmask),
    .binary       (binary),
    .result       (result)
  );
endmodule

// File: tb/cmac_neuron_bench.sv
module cmac_neuron_bench;
  localparam int NC = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [6:0]    wr_idx = '0;
  logic [15:0]   wr_data = '0;
  logic [3:0]    cfg_wprec_m1 = '0;
  logic [3:0]    cfg_iprec_m1 = '0;
  logic          start = 1'b0;
  logic          in_valid = 1'b0;
  logic [NC-1:0] in_bits = '0;
  logic          busy;
  logic          done;
  logic [38:0]   result;

  int total = 0;
  int bad = 0;

  logic [15:0]   wm   [NC];
  logic [NC-1:0] vecs [16];

  always #5 clk = ~clk;

  cmac_neuron u_cmac_neuron (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .cfg_wprec_m1, .cfg_iprec_m1,
    .start, .in_valid, .in_bits, .busy, .done, .result
  );

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned model(int wp, int ip);
    longint unsigned s = 0;
    longint unsigned mask = (64'd1 << wp) - 1;
    if (wp == 1 && ip == 1) begin
      for (int c = 0; c < NC; c++) if (vecs[0][c] == wm[c][0]) s++;
    end else begin
      for (int k = 0; k < ip; k++)
        for (int c = 0; c < NC; c++)
          if (vecs[k][c]) s += (longint'(wm[c]) & mask) << k;
    end
    return s;
  endfunction

  task automatic write_w(int idx, logic [15:0] d);
    wr_en = 1'b1; wr_idx = 7'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wm[idx] = d;
  endtask

  task automatic load_random();
    for (int c = 0; c < NC; c++) write_w(c, 16'($urandom));
  endtask

  task automatic rand_vecs();
    for (int k = 0; k < 16; k++)
      vecs[k] = {$urandom, $urandom, $urandom, $urandom};
  endtask

  // gap: idle cycle with junk inputs before bit 1; spur: start during that gap;
  // midwr: write to column 0 during bit 0 (must be dropped)
  task automatic run(string req, int wp, int ip, bit gap, bit spur, bit midwr);
    longint unsigned exp_v;
    longint unsigned held;
    cfg_wprec_m1 = 4'(wp - 1); cfg_iprec_m1 = 4'(ip - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_wprec_m1 = 4'($urandom); cfg_iprec_m1 = 4'($urandom);
    for (int k = 0; k < ip; k++) begin
      if (gap && k == 1) begin
        in_valid = 1'b0; in_bits = ~vecs[k]; start = spur;
        @(negedge clk);
        start = 1'b0;
      end
      in_valid = 1'b1; in_bits = vecs[k];
      if (midwr && k == 0) begin
        wr_en = 1'b1; wr_idx = 7'd0; wr_data = ~wm[0];
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    in_valid = 1'b0; in_bits = '0;
    exp_v = model(wp, ip);
    check({req, " R7 done"}, 64'(done), 1);
    check({req, " R7 busy"}, 64'(busy), 0);
    check({req, " result"}, 64'(result), exp_v);
    held = 64'(result);
    @(negedge clk);
    check({req, " R7 done low"}, 64'(done), 0);
    check({req, " R8 hold"}, 64'(result), held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int c = 0; c < NC; c++) wm[c] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 result", 64'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R2: random precisions
    for (int t = 0; t < 10; t++) begin
      load_random();
      rand_vecs();
      run("R5 R4 random", 2 + int'($urandom_range(0, 14)), 1 + int'($urandom_range(0, 15)), 0, 0, 0);
    end

    // R2: high bits ignored at 4-bit precision
    for (int c = 0; c < NC; c++) write_w(c, 16'hFFF0 | 16'(c & 15));
    rand_vecs();
    run("R2 mask", 4, 3, 0, 0, 0);

    // R6: binary mode
    load_random(); rand_vecs();
    run("R6 binary", 1, 1, 0, 0, 0);
    for (int c = 0; c < NC; c++) vecs[0][c] = wm[c][0];
    run("R6 all match", 1, 1, 0, 0, 0);
    vecs[0] = ~vecs[0];
    run("R6 none match", 1, 1, 0, 0, 0);

    // R3: write during run dropped (model keeps old weight)
    load_random(); rand_vecs();
    run("R3 busy write", 8, 4, 0, 0, 1);
    run("R3 weight kept", 8, 4, 0, 0, 0);

    // R9: idle gap and spurious start
    rand_vecs();
    run("R9 gap", 12, 6, 1, 1, 0);
    run("R9 gap2", 16, 16, 1, 0, 0);

    // R10: maximum operands
    for (int c = 0; c < NC; c++) write_w(c, 16'hFFFF);
    for (int k = 0; k < 16; k++) vecs[k] = '1;
    run("R10 max", 16, 16, 0, 0, 0);
    check("R10 exact", 64'(result), 64'd128 * 64'd65535 * 64'd65535);

    // R8: start clears result
    cfg_wprec_m1 = 4'd3; cfg_iprec_m1 = 4'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 cleared", 64'(result), 0);
    check("R8 busy", 64'(busy), 1);
    in_valid = 1'b1; in_bits = '0;
    @(negedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R8 zero run", 64'(result), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule